// File: doc/BRIEF.md
# Stretched-Cycle Two-Phase CPU Clock Generator

This block derives a two-phase processor clock from a fast master clock and keeps that clock in step with the horizontal video line. A processor cycle normally spans a fixed number of master ticks. The first half is phase 0 and the second half is phase 1. The final cycle of each scan line is longer by a few ticks. Because of this, a line always covers a whole number of color-subcarrier periods while the processor runs at a slightly uneven rate.

During phase 0 the processor leaves the memory bus alone. In the middle of that phase the block raises a one-tick video-slot pulse, and the video scanner uses it to fetch display memory. The block also exports the index of the current cycle within the line. The scanner reads this index to form its horizontal address.

With default parameters, a 14.31818 MHz master clock gives 14-tick cycles of about 978 ns. The stretched 16-tick cycle lasts about 1117 ns. The average processor rate is about 1.0205 MHz.

Top module: `stretch_clkgen`

## Requirements
- R1: A synchronous active-high reset sets the line cycle index to 0 and starts the first tick of phase 0. `cpuPh0`=1, `cpuPh1`=0 and `videoSlot`=0 hold on the first tick after reset is released.
- R2: Cycles 0 to 63 each last 14 master ticks. Phase 0 (`cpuPh0`=1) covers ticks 0 to 6 and phase 1 (`cpuPh1`=1) covers ticks 7 to 13.
- R3: Cycle 64, the last cycle of the line, lasts 16 ticks. Phase 0 keeps its 7 ticks and phase 1 grows to 9 ticks.
- R4: `lineCycle` holds its value for a whole cycle. It steps by one at each cycle boundary, and after 64 it wraps to 0.
- R5: Exactly one of `cpuPh0` and `cpuPh1` is high on every tick out of reset.
- R6: `videoSlot` is high for exactly one tick per cycle, at tick 3 of phase 0, and never during phase 1.
- R7: One full line, from the start of cycle 0 to the next start of cycle 0, lasts 912 master ticks.
- R8: A reset asserted in the middle of a cycle abandons that cycle. After release the sequence restarts at cycle 0, tick 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuPh0 | output | 1 | High during processor phase 0 (bus idle) |
| cpuPh1 | output | 1 | High during processor phase 1 |
| videoSlot | output | 1 | One-tick strobe in the middle of phase 0 that grants the bus to the video scanner |
| lineCycle | output | 7 | Index of the current processor cycle within the line, 0 to 64 |

## Verification
The bench walks every tick of whole lines, so it catches a stretch placed on the wrong cycle (for example on cycle 0, or on every cycle). A stretch added to phase 0 rather than phase 1 shifts the video slot and the phase boundary, and the bench sees that too. It checks the 64-to-0 wrap: a counter that wrapped at 63 or 65 would break the 912-tick line length and the index sequence. A reset in the middle of a cycle checks that the tick counter restarts together with the cycle index. A design that cleared only one of them would start the next line with a short or misplaced phase.

// File: rtl/stretch_clkgen_pkg.sv
package stretch_clkgen_pkg;
  // Strobes the tick sequencer hands to the cycle datapath
  typedef struct packed {
    logic cycleEnd;  // last tick of the current processor cycle
    logic slotTick;  // mid-phase-0 tick reserved for the video fetch
    logic inPh1;     // current tick belongs to phase 1
  } clkStrobe_t;
endpackage

// File: rtl/stretch_clkgen_ctrl.sv
module stretch_clkgen_ctrl
  import stretch_clkgen_pkg::*;
#(
  parameter int NORM_TICKS  = 14,
  parameter int EXTRA_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lastCycle,
  output clkStrobe_t stb
);
  localparam int LONG_TICKS = NORM_TICKS + EXTRA_TICKS;
  localparam int TW         = $clog2(LONG_TICKS);
  localparam int PH0_TICKS  = NORM_TICKS / 2;
  localparam int SLOT_AT    = PH0_TICKS / 2;

  localparam logic [TW-1:0] NORM_END = TW'(NORM_TICKS - 1);
  localparam logic [TW-1:0] LONG_END = TW'(LONG_TICKS - 1);
  localparam logic [TW-1:0] PH1_AT   = TW'(PH0_TICKS);
  localparam logic [TW-1:0] SLOT_POS = TW'(SLOT_AT);

  logic [TW-1:0] tickCnt;
  logic [TW-1:0] endTick;
  logic          endNow;

  // Only the final cycle of the line runs to the longer end tick
  always_comb begin
    endTick = lastCycle ? LONG_END : NORM_END;
    endNow  = (tickCnt == endTick);
  end

  always_ff @(posedge clk) begin
    if (rst)         tickCnt <= '0;
    else if (endNow) tickCnt <= '0;
    else             tickCnt <= tickCnt + 1'b1;
  end

  // Phase 0 has a fixed length, so the extra ticks land in phase 1
  always_comb begin
    stb.cycleEnd = endNow;
    stb.slotTick = (tickCnt == SLOT_POS);
    stb.inPh1    = (tickCnt >= PH1_AT);
  end
endmodule

// File: rtl/stretch_clkgen_dp.sv
module stretch_clkgen_dp
  import stretch_clkgen_pkg::*;
#(
  parameter int LINE_CYCLES = 65,
  parameter int CW          = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  clkStrobe_t    stb,
  output logic          lastCycle,
  output logic          cpuPh0,
  output logic          cpuPh1,
  output logic          videoSlot,
  output logic [CW-1:0] lineCycle
);
  localparam logic [CW-1:0] LAST_IDX = CW'(LINE_CYCLES - 1);

  logic [CW-1:0] cycleCnt;

  always_ff @(posedge clk) begin
    if (rst)                cycleCnt <= '0;
    else if (stb.cycleEnd) begin
      if (lastCycle)        cycleCnt <= '0;
      else                  cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    lastCycle = (cycleCnt == LAST_IDX);
    cpuPh0    = ~stb.inPh1;
    cpuPh1    = stb.inPh1;
    videoSlot = stb.slotTick & ~stb.inPh1;
    lineCycle = cycleCnt;
  end
endmodule

// File: rtl/stretch_clkgen.sv
module stretch_clkgen
  import stretch_clkgen_pkg::*;
#(
  parameter int NORM_TICKS  = 14,
  parameter int EXTRA_TICKS = 2,
  parameter int LINE_CYCLES = 65,
  parameter int CW          = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cpuPh0,
  output logic          cpuPh1,
  output logic          videoSlot,
  output logic [CW-1:0] lineCycle
);
  clkStrobe_t stb;
  logic       lastCycle;

  stretch_clkgen_ctrl #(
    .NORM_TICKS (NORM_TICKS),
    .EXTRA_TICKS(EXTRA_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lastCycle(lastCycle),
    .stb      (stb)
  );

  stretch_clkgen_dp #(
    .LINE_CYCLES(LINE_CYCLES),
    .CW         (CW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .lastCycle(lastCycle),
    .cpuPh0   (cpuPh0),
    .cpuPh1   (cpuPh1),
    .videoSlot(videoSlot),
    .lineCycle(lineCycle)
  );
endmodule

// File: rtl/stretch_clkgen_chk.sv
module stretch_clkgen_chk #(
  parameter int NORM_TICKS  = 14,
  parameter int EXTRA_TICKS = 2,
  parameter int LINE_CYCLES = 65,
  parameter int CW          = $clog2(LINE_CYCLES)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpuPh0,
  input logic          cpuPh1,
  input logic          videoSlot,
  input logic [CW-1:0] lineCycle
);
  localparam int PH1_NORM = NORM_TICKS - NORM_TICKS / 2;
  localparam int PH1_LONG = PH1_NORM + EXTRA_TICKS;
  localparam logic [CW-1:0] LAST_IDX = CW'(LINE_CYCLES - 1);

  logic [7:0] ph1Run;
  logic       rstD;

  // Length of the phase-1 run that has just ended
  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rst)         ph1Run <= '0;
    else if (cpuPh1) ph1Run <= ph1Run + 1'b1;
    else             ph1Run <= '0;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (lineCycle == '0 && cpuPh0 && !cpuPh1 && !videoSlot));

  a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot({cpuPh0, cpuPh1}));

  a_r6_slot_in_ph0: assert property (@(posedge clk) disable iff (rst)
    videoSlot |-> cpuPh0);

  a_r2_ph1_length: assert property (@(posedge clk) disable iff (rst || rstD)
    (cpuPh0 && ph1Run != 0) |-> (ph1Run == PH1_NORM || ph1Run == PH1_LONG));

  a_r3_long_on_last: assert property (@(posedge clk) disable iff (rst || rstD)
    (cpuPh0 && ph1Run == PH1_LONG) |-> (lineCycle == '0));

  a_r4_index_step: assert property (@(posedge clk) disable iff (rst || rstD)
    (lineCycle != $past(lineCycle)) |->
      ((lineCycle == $past(lineCycle) + 1'b1) ||
       (lineCycle == '0 && $past(lineCycle) == LAST_IDX)));

  a_r4_step_at_boundary: assert property (@(posedge clk) disable iff (rst || rstD)
    (lineCycle != $past(lineCycle)) |-> (cpuPh0 && $past(cpuPh1)));
endmodule

bind stretch_clkgen stretch_clkgen_chk #(
  .NORM_TICKS (NORM_TICKS),
  .EXTRA_TICKS(EXTRA_TICKS),
  .LINE_CYCLES(LINE_CYCLES),
  .CW         (CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpuPh0   (cpuPh0),
  .cpuPh1   (cpuPh1),
  .videoSlot(videoSlot),
  .lineCycle(lineCycle)
);

// File: tb/stretch_clkgen_tb.sv
module stretch_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpuPh0, cpuPh1, videoSlot;
  logic [6:0] lineCycle;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stretch_clkgen u_dut (
    .clk      (clk),
    .rst      (rst),
    .cpuPh0   (cpuPh0),
    .cpuPh1   (cpuPh1),
    .videoSlot(videoSlot),
    .lineCycle(lineCycle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Outputs are sampled at the falling edge, directly after a step
  task automatic step();
    @(negedge clk);
  endtask

  // R1/R8: state on the first tick out of reset
  task automatic checkStartState(input string req);
    check(lineCycle == 0, req, lineCycle, 0);
    check(cpuPh0 && !cpuPh1, req, {cpuPh0, cpuPh1}, 2);
    check(!videoSlot, req, videoSlot, 0);
  endtask

  // Walks one full line tick by tick; must begin on cycle 0, tick 0
  task automatic walkLine();
    for (int c = 0; c < 65; c++) begin
      int len = (c == 64) ? 16 : 14;
      int badPh = 0, badOne = 0, badSlot = 0, badCnt = 0;
      for (int t = 0; t < len; t++) begin
        if (cpuPh0 != (t < 7)) badPh++;
        if (cpuPh0 == cpuPh1) badOne++;
        if (videoSlot != (t == 3)) badSlot++;
        if (lineCycle != c) badCnt++;
        step();
      end
      if (c == 64) check(badPh == 0, "R3 long cycle phases", badPh, 0);
      else         check(badPh == 0, "R2 normal cycle phases", badPh, 0);
      check(badOne == 0, "R5 one phase high", badOne, 0);
      check(badSlot == 0, "R6 video slot position", badSlot, 0);
      check(badCnt == 0, "R4 cycle index", badCnt, 0);
    end
    // R4: wrap back to 0 after cycle 64
    check(lineCycle == 0 && cpuPh0, "R4 wrap to 0", lineCycle, 0);
  endtask

  // R7: ticks from one start of cycle 0 to the next
  task automatic measureLine();
    int n = 0;
    logic [6:0] prev;
    prev = lineCycle;
    step(); n++;
    while (!(lineCycle == 0 && prev == 64) && n < 2000) begin
      prev = lineCycle;
      step(); n++;
    end
    check(n == 912, "R7 line length", n, 912);
  endtask

  // R8: reset asserted during phase 1 of cycle 5
  task automatic midCycleReset();
    while (!(lineCycle == 5 && cpuPh1)) step();
    step(); step();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    checkStartState("R8 restart after mid-cycle reset");
    walkLine();
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    checkStartState("R1 reset state");
    walkLine();
    walkLine();
    measureLine();
    midCycleReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule